// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter for a stream of word-aligned 32-bit instructions. It drives the counter out as the fetch address. On every rising clock edge it loads one of two values. The first is the address of the next word in sequence. The second is a relative branch target. The target is computed from the 16-bit displacement held in the low half of the instruction currently being fetched.

The branch path is selected only when the control unit requests a branch and an external comparator reports that the two operands are equal. In every other case the counter steps to the next word. The counter shares the clock edge with every other storage element in the processor, so the new address appears one edge after the inputs that chose it. Fetch memory, instruction decoding and the operand comparison are all outside this block.

Top module: `nxa_fetch_pc`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads `RESET_VEC` (default 0x00000000) on that edge. Reset takes priority over both branch inputs.
- R2: With `branch_sel` low and `cond_equal` low, each rising edge sets PC to PC + 4.
- R3: With `branch_sel` high and `cond_equal` high, each edge sets PC to PC + 4 + (sign-extended `instr_word[15:0]` shifted left by two). The displacement is a two's-complement word count.
- R4: With `branch_sel` high and `cond_equal` low, the branch is not taken and PC becomes PC + 4.
- R5: With `cond_equal` high and `branch_sel` low, the branch is not taken and PC becomes PC + 4.
- R6: When bit 15 of `instr_word` is set, a taken branch moves the PC backwards by the two's-complement value of the displacement times four.
- R7: All address sums wrap modulo 2^32 and there is no overflow indication. PC 0xFFFFFFFC steps to 0x00000000.
- R8: Bits [1:0] of `pc_out` are always zero.
- R9: Bits [31:16] of `instr_word` have no effect on the next PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates happen on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 32 | Current instruction word; bits [15:0] hold the branch displacement |
| branch_sel | input | 1 | High when the control unit requests a conditional branch |
| cond_equal | input | 1 | High when the external comparator reports equal operands |
| pc_out | output | 32 | Current program counter and fetch address |

## Verification
Every result of this block is due exactly one rising edge after the inputs that produced it. This holds for the sequential step, the taken target and the reset value, because the only register on the path is the PC itself and its output drives `pc_out` directly. The bench changes the inputs on a falling edge and lets exactly one rising edge pass. It then samples `pc_out` a quarter period later and compares it with a reference counter kept in the bench, which is advanced by the same rule. Because each input set meets only one edge, every comparison covers exactly one update.

// File: rtl/nxa_pkg.sv
package nxa_pkg;
   // Two ways to build the next-address arithmetic.
   typedef enum logic [0:0] {
      NXA_SPLIT_ADDERS = 1'b0,  // incrementer plus target adder, select at the end
      NXA_MERGED_ADDER = 1'b1   // one adder with a selected second operand
   } nxa_arch_e;

   localparam int unsigned NXA_DEF_ADDR_W  = 32;
   localparam int unsigned NXA_DEF_INSTR_W = 32;
   localparam int unsigned NXA_DEF_OFS_W   = 16;
   localparam int unsigned NXA_DEF_ALIGN   = 2;
endpackage

// File: rtl/nxa_offset_ext.sv
// Sign-extends the displacement field and scales it to a byte offset.
module nxa_offset_ext #(
   parameter int unsigned ADDR_W = nxa_pkg::NXA_DEF_ADDR_W,
   parameter int unsigned OFS_W  = nxa_pkg::NXA_DEF_OFS_W,
   parameter int unsigned ALIGN  = nxa_pkg::NXA_DEF_ALIGN
) (
   input  logic [OFS_W-1:0]  disp,
   output logic [ADDR_W-1:0] byte_ofs
);
   localparam int unsigned EXT_W = ADDR_W - OFS_W - ALIGN;

   if (ADDR_W <= OFS_W + ALIGN) begin : g_bad_width
      $error("nxa_offset_ext: ADDR_W must exceed OFS_W + ALIGN");
   end

   always_comb begin
      byte_ofs = {{EXT_W{disp[OFS_W-1]}}, disp, {ALIGN{1'b0}}};
   end
endmodule

// File: rtl/nxa_target_calc.sv
// Computes the next PC from the current PC, scaled offset and take decision.
module nxa_target_calc
   import nxa_pkg::*;
#(
   parameter int unsigned ADDR_W = NXA_DEF_ADDR_W,
   parameter int unsigned ALIGN  = NXA_DEF_ALIGN,
   parameter nxa_arch_e   ARCH   = NXA_SPLIT_ADDERS
) (
   input  logic [ADDR_W-1:0] pc_cur,
   input  logic [ADDR_W-1:0] byte_ofs,
   input  logic              take,
   output logic [ADDR_W-1:0] pc_next
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

   if (ARCH == NXA_SPLIT_ADDERS) begin : g_split
      logic [ADDR_W-1:0] seq_addr;
      logic [ADDR_W-1:0] tgt_addr;
      always_comb begin
         seq_addr = pc_cur + STEP;
         tgt_addr = seq_addr + byte_ofs;
         pc_next  = take ? tgt_addr : seq_addr;
      end
   end else begin : g_merged
      logic [ADDR_W-1:0] addend;
      always_comb begin
         addend  = take ? (STEP + byte_ofs) : STEP;
         pc_next = pc_cur + addend;
      end
   end
endmodule

// File: rtl/nxa_pc_reg.sv
// Program counter register with synchronous reset to a fixed vector.
module nxa_pc_reg #(
   parameter int unsigned       ADDR_W    = nxa_pkg::NXA_DEF_ADDR_W,
   parameter int unsigned       ALIGN     = nxa_pkg::NXA_DEF_ALIGN,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc_d,
   output logic [ADDR_W-1:0] pc_q
);
   logic [ADDR_W-ALIGN-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) word_q <= RESET_VEC[ADDR_W-1:ALIGN];
      else     word_q <= pc_d[ADDR_W-1:ALIGN];
   end

   // Only the word index is stored; the low bits are tied off.
   logic unused_low;
   assign unused_low = ^pc_d[ALIGN-1:0];
   assign pc_q       = {word_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/nxa_fetch_pc.sv
module nxa_fetch_pc
   import nxa_pkg::*;
#(
   parameter int unsigned       ADDR_W    = NXA_DEF_ADDR_W,
   parameter int unsigned       INSTR_W   = NXA_DEF_INSTR_W,
   parameter int unsigned       OFS_W     = NXA_DEF_OFS_W,
   parameter int unsigned       ALIGN     = NXA_DEF_ALIGN,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0,
   parameter nxa_arch_e         ARCH      = NXA_SPLIT_ADDERS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic              branch_sel,
   input  logic              cond_equal,
   output logic [ADDR_W-1:0] pc_out
);
   if (INSTR_W <= OFS_W) begin : g_bad_instr
      $error("nxa_fetch_pc: INSTR_W must exceed OFS_W");
   end
   if (ALIGN < 1) begin : g_bad_align
      $error("nxa_fetch_pc: ALIGN must be at least 1");
   end
   if (RESET_VEC[ALIGN-1:0] != '0) begin : g_bad_vec
      $error("nxa_fetch_pc: RESET_VEC must be aligned");
   end

   logic [ADDR_W-1:0] byte_ofs;
   logic [ADDR_W-1:0] pc_next;
   logic              take;
   logic              unused_upper;

   assign take         = branch_sel & cond_equal;
   assign unused_upper = ^instr_word[INSTR_W-1:OFS_W];

   nxa_offset_ext #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ALIGN(ALIGN)
   ) u_ext (
      .disp    (instr_word[OFS_W-1:0]),
      .byte_ofs(byte_ofs)
   );

   nxa_target_calc #(
      .ADDR_W(ADDR_W), .ALIGN(ALIGN), .ARCH(ARCH)
   ) u_calc (
      .pc_cur  (pc_out),
      .byte_ofs(byte_ofs),
      .take    (take),
      .pc_next (pc_next)
   );

   nxa_pc_reg #(
      .ADDR_W(ADDR_W), .ALIGN(ALIGN), .RESET_VEC(RESET_VEC)
   ) u_pc (
      .clk (clk),
      .rst (rst),
      .pc_d(pc_next),
      .pc_q(pc_out)
   );
endmodule

// File: rtl/nxa_fetch_pc_chk.sv
module nxa_fetch_pc_chk #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       INSTR_W   = 32,
   parameter int unsigned       OFS_W     = 16,
   parameter int unsigned       ALIGN     = 2,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr_word,
   input logic               branch_sel,
   input logic               cond_equal,
   input logic [ADDR_W-1:0]  pc_out
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

   logic [ADDR_W-1:0] exp_ofs;
   assign exp_ofs = ADDR_W'($signed(instr_word[OFS_W-1:0])) << ALIGN;

   assert_reset_vec_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_out == RESET_VEC));

   // Covers R2, R4 and R5: anything short of both controls high steps by one word.
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      !(branch_sel && cond_equal) |=> (pc_out == $past(pc_out) + STEP));

   // Covers R3, R6 and R7: taken target with modular wrap.
   assert_taken_R3: assert property (@(posedge clk) disable iff (rst)
      (branch_sel && cond_equal) |=> (pc_out == $past(pc_out) + STEP + $past(exp_ofs)));

   assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
      pc_out[ALIGN-1:0] == '0);
endmodule

bind nxa_fetch_pc nxa_fetch_pc_chk #(
   .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFS_W(OFS_W),
   .ALIGN(ALIGN), .RESET_VEC(RESET_VEC)
) u_chk (
   .clk(clk), .rst(rst), .instr_word(instr_word),
   .branch_sel(branch_sel), .cond_equal(cond_equal), .pc_out(pc_out)
);

// File: tb/nxa_fetch_pc_test.sv
module nxa_fetch_pc_test;
   localparam int          PERIOD    = 10;
   localparam logic [31:0] RESET_VEC = 32'h0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_word = '0;
   logic        branch_sel = 1'b0;
   logic        cond_equal = 1'b0;
   logic [31:0] pc_out;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   logic [31:0] model_pc = RESET_VEC;

   always #(PERIOD/2) clk = ~clk;

   nxa_fetch_pc uut (
      .clk(clk), .rst(rst), .instr_word(instr_word),
      .branch_sel(branch_sel), .cond_equal(cond_equal), .pc_out(pc_out)
   );

   // {instr_word, branch_sel, cond_equal}
   localparam int NVEC = 10;
   localparam logic [33:0] VEC [NVEC] = '{
      {32'h0000_0000, 1'b0, 1'b0},
      {32'h1234_0008, 1'b0, 1'b0},
      {32'h0000_0010, 1'b0, 1'b1},
      {32'h0000_0010, 1'b1, 1'b0},
      {32'h0000_0003, 1'b1, 1'b1},
      {32'hFFFF_0000, 1'b1, 1'b1},
      {32'h0000_FFFC, 1'b1, 1'b1},
      {32'hABCD_7FFF, 1'b1, 1'b1},
      {32'h0000_8000, 1'b1, 1'b1},
      {32'h0000_8000, 1'b0, 1'b0}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: pc_out=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] iw, input logic sel, input logic eq,
                       input string req);
      logic [31:0] ofs;
      @(negedge clk);
      rst = 1'b0;
      instr_word = iw;
      branch_sel = sel;
      cond_equal = eq;
      ofs = {{14{iw[15]}}, iw[15:0], 2'b00};
      model_pc = model_pc + 32'd4 + ((sel && eq) ? ofs : 32'd0);
      @(posedge clk);
      #(PERIOD/4);
      check(pc_out, model_pc, req);
      check({30'd0, pc_out[1:0]}, 32'd0, "R8");
   endtask

   task automatic do_reset(input logic sel, input logic eq);
      @(negedge clk);
      rst = 1'b1;
      branch_sel = sel;
      cond_equal = eq;
      instr_word = 32'h0000_0100;
      @(posedge clk);
      #(PERIOD/4);
      model_pc = RESET_VEC;
      check(pc_out, RESET_VEC, "R1");
   endtask

   function automatic string tag_of(input logic [33:0] v);
      if (v[1] && v[0]) return v[17] ? "R6" : "R3";
      if (v[1]) return "R4";
      if (v[0]) return "R5";
      return (v[33:18] != '0) ? "R9" : "R2";
   endfunction

   initial begin
      do_reset(1'b0, 1'b0);
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][33:2], VEC[i][1], VEC[i][0], tag_of(VEC[i]));
      end
      // R1: reset wins over a taken branch
      do_reset(1'b1, 1'b1);
      // R7: backward branch from 0 wraps to the top word, then steps to 0
      step(32'h0000_FFFE, 1'b1, 1'b1, "R7");
      check(pc_out, 32'hFFFF_FFFC, "R7");
      step(32'h0000_0000, 1'b0, 1'b0, "R7");
      check(pc_out, 32'h0000_0000, "R7");
      // R7: forward branch from the top word wraps past zero
      step(32'h0000_FFFE, 1'b1, 1'b1, "R7");
      step(32'h0000_0001, 1'b1, 1'b1, "R7");
      check(pc_out, 32'h0000_0004, "R7");
      // R9: upper bits alone differ, no branch effect difference
      step(32'hFFFF_0002, 1'b1, 1'b1, "R9");
      check(pc_out, 32'h0000_0010, "R9");
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: run did not complete");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule